// File: doc/BRIEF.md
# Scanline IRQ down-counter

This block raises an interrupt after a programmed number of rising edges on the picture-bus address line A12, as a cartridge does to split the screen at a chosen scanline. A12 rises once per scanline during pattern fetches, but it also toggles briefly at other times. A rise therefore counts only after A12 has stayed low for a minimum number of CPU-cycle ticks. Counted rises decrement an 8-bit counter. When the counter runs out, the block sets a pending flag, drives the interrupt line high and disarms itself. Firmware must re-arm it before it can fire again.

The CPU programs the block with plain writes into one 4 KiB address page. The low three address bits choose the action: acknowledge, arm or load. Enable and pending are held as a four-state machine:

- `ST_IDLE`: disarmed, nothing pending.
- `ST_ARMED`: armed, nothing pending.
- `ST_FIRED`: disarmed, pending.
- `ST_ARMED_PEND`: armed, with an earlier interrupt still unacknowledged.

The transitions are:

- Ack: any state goes to `ST_IDLE`.
- Arm: `ST_IDLE` goes to `ST_ARMED`, and `ST_FIRED` goes to `ST_ARMED_PEND`.
- Expire: a counted rise that empties or finds an empty counter takes `ST_ARMED` or `ST_ARMED_PEND` to `ST_FIRED`.

Top module: `scanline_irq_counter`

## Requirements
- R1: After reset `irq` is low, the counter holds 0 and the block is disarmed.
- R2: A write is decoded only when address bits 15:12 equal 4'hC. Bits 2:0 select the action: 2 is ack, 3 is arm, 5 is load. Bits 11:3 are ignored, and writes to other pages or other offsets change nothing.
- R3: An ack write disarms the block and clears pending, so `irq` is low on the next cycle.
- R4: An arm write sets the enable and leaves pending as it was.
- R5: A load write copies `cpu_data` into the counter.
- R6: A rise of `ppu_a12` is counted only if A12 was low across at least 3 `cpu_tick` pulses since it last went low. Shorter lows are ignored.
- R7: A counted rise while armed with a nonzero count decrements the counter. When the result is zero, pending is set and the block disarms.
- R8: A counted rise while armed with the counter already at zero sets pending and disarms without decrementing.
- R9: While disarmed, counted rises are ignored and the counter keeps its value.
- R10: `irq` is high exactly while pending is set, and it stays high until an ack write.
- R11: A write into the register page in the same cycle as a counted rise takes effect, and that rise is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_tick | input | 1 | One-cycle pulse per CPU cycle, clocks the A12 low-time filter |
| ppu_a12 | input | 1 | Picture-bus address line A12 |
| irq | output | 1 | Interrupt request, level high while pending |

## Verification
The bench builds the block with its default parameters:

- an 8-bit counter;
- a three-tick low threshold;
- the register page at 4'hC.

It pulses `cpu_tick` every third clock. A twelve-clock low phase therefore clears the filter, and a three-clock low phase falls short of it, which brings the R6 boundary within a few cycles. Small loads of 0 to 3 reach expiry, zero-count firing and re-arming in a handful of scanline pulses. A behavioural model that tracks count, enable, pending and low time in plain integers is compared with `irq` on every clock.

// File: rtl/scanline_irq_pkg.sv
package scanline_irq_pkg;

    // Enable and pending flags, kept as one state.
    typedef enum logic [1:0] {
        ST_IDLE       = 2'b00,
        ST_ARMED      = 2'b01,
        ST_FIRED      = 2'b10,
        ST_ARMED_PEND = 2'b11
    } irq_state_e;

    // Decoded CPU register action.
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_ACK   = 3'd1,
        OP_ARM   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_OTHER = 3'd4
    } reg_op_e;

endpackage

// File: rtl/a12_rise_filter.sv
module a12_rise_filter #(
    parameter int LOW_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a12,
    input  logic tick,
    output logic rise
);
    localparam int CW = $clog2(LOW_TICKS + 1);
    localparam logic [CW-1:0] LOW_MAX = CW'(LOW_TICKS);

    logic          a12_q;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a12_q   <= 1'b0;
            low_cnt <= '0;
        end else begin
            a12_q <= a12;
            if (a12) begin
                low_cnt <= '0;
            end else if (tick && (low_cnt != LOW_MAX)) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    // A low-to-high step counts only after a long enough low phase.
    always_comb begin
        rise = a12 && !a12_q && (low_cnt >= LOW_MAX);
    end

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import scanline_irq_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter logic [3:0] PAGE     = 4'hC,
    parameter logic [2:0] ACK_SEL  = 3'd2,
    parameter logic [2:0] ARM_SEL  = 3'd3,
    parameter logic [2:0] LOAD_SEL = 3'd5
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    output reg_op_e           op
);
    logic       page_hit;
    logic [2:0] sel;

    always_comb begin
        page_hit = cpu_we && (cpu_addr[ADDR_W-1 -: 4] == PAGE);
        sel      = cpu_addr[2:0];
        if (!page_hit) begin
            op = OP_NONE;
        end else if (sel == ACK_SEL) begin
            op = OP_ACK;
        end else if (sel == ARM_SEL) begin
            op = OP_ARM;
        end else if (sel == LOAD_SEL) begin
            op = OP_LOAD;
        end else begin
            op = OP_OTHER;
        end
    end

endmodule

// File: rtl/irq_count_fsm.sv
module irq_count_fsm
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_op_e          op,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rise,
    output logic [CNT_W-1:0] cnt,
    output logic             armed,
    output logic             pending
);
    irq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             edge_ok;
    logic             is_armed;
    logic             fire_now;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and next count.
    always_comb begin
        // A register write in the same cycle wins over the rise.
        edge_ok  = rise && (op == OP_NONE);
        is_armed = (state_q == ST_ARMED) || (state_q == ST_ARMED_PEND);
        fire_now = (cnt_q == CNT_W'(0)) || (cnt_q == CNT_W'(1));
        state_d  = state_q;
        cnt_d    = cnt_q;

        unique case (state_q)
            ST_IDLE: begin
                if (op == OP_ARM) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (op == OP_ACK)               state_d = ST_IDLE;
                else if (edge_ok && fire_now)   state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (op == OP_ACK)               state_d = ST_IDLE;
                else if (op == OP_ARM)          state_d = ST_ARMED_PEND;
            end
            ST_ARMED_PEND: begin
                if (op == OP_ACK)               state_d = ST_IDLE;
                else if (edge_ok && fire_now)   state_d = ST_FIRED;
            end
        endcase

        if (op == OP_LOAD) begin
            cnt_d = wr_data;
        end else if (edge_ok && is_armed && (cnt_q != CNT_W'(0))) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        unique case (state_q)
            ST_IDLE:       begin armed = 1'b0; pending = 1'b0; end
            ST_ARMED:      begin armed = 1'b1; pending = 1'b0; end
            ST_FIRED:      begin armed = 1'b0; pending = 1'b1; end
            ST_ARMED_PEND: begin armed = 1'b1; pending = 1'b1; end
        endcase
        cnt = cnt_q;
    end

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scanline_irq_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         DATA_W    = 8,
    parameter int         CNT_W     = 8,
    parameter int         LOW_TICKS = 3,
    parameter logic [3:0] PAGE      = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_we,
    input  logic              cpu_tick,
    input  logic              ppu_a12,
    output logic              irq
);
    reg_op_e          op;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic             armed;
    logic             pending;

    a12_rise_filter #(
        .LOW_TICKS(LOW_TICKS)
    ) u_filter (
        .clk  (clk),
        .rst_n(rst_n),
        .a12  (ppu_a12),
        .tick (cpu_tick),
        .rise (rise)
    );

    irq_reg_decode #(
        .ADDR_W(ADDR_W),
        .PAGE  (PAGE)
    ) u_decode (
        .cpu_addr(cpu_addr),
        .cpu_we  (cpu_we),
        .op      (op)
    );

    irq_count_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .wr_data(cpu_data[CNT_W-1:0]),
        .rise   (rise),
        .cnt    (cnt_q),
        .armed  (armed),
        .pending(pending)
    );

    assign irq = pending;

endmodule

// File: rtl/irq_counter_checker.sv
module irq_counter_checker #(
    parameter int         ADDR_W = 16,
    parameter int         DATA_W = 8,
    parameter int         CNT_W  = 8,
    parameter logic [3:0] PAGE   = 4'hC
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic              cpu_we,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic              armed
);
    logic in_page;
    assign in_page = cpu_we && (cpu_addr[ADDR_W-1 -: 4] == PAGE);

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_page && cpu_addr[2:0] == 3'd2) |=> (!irq && !armed));

    assert_arm_keeps_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_page && cpu_addr[2:0] == 3'd3) |=> (armed && irq == $past(irq)));

    assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_page && cpu_addr[2:0] == 3'd5) |=> (cnt == $past(cpu_data[CNT_W-1:0])));

    assert_fire_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (cnt == '0 && !armed));

    assert_hold_disarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !cpu_we) |=> $stable(cnt));

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(in_page && cpu_addr[2:0] == 3'd2)) |=> irq);

endmodule

bind scanline_irq_counter irq_counter_checker #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .PAGE  (PAGE)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_addr(cpu_addr),
    .cpu_data(cpu_data),
    .cpu_we  (cpu_we),
    .irq     (irq),
    .cnt     (cnt_q),
    .armed   (armed)
);

// File: tb/tb_scanline_irq_counter.sv
`timescale 1ns/1ps
module tb_scanline_irq_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_tick = 1'b0;
    logic        ppu_a12 = 1'b1;
    logic        irq;

    int total = 0;
    int fails = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    scanline_irq_counter dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_we(cpu_we), .cpu_tick(cpu_tick), .ppu_a12(ppu_a12), .irq(irq)
    );

    // CPU tick every third clock.
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 3;
            cpu_tick = (ph == 0);
        end
    end

    // Behavioural reference model.
    int m_cnt = 0, m_low = 0;
    bit m_en = 0, m_pend = 0, m_prev = 0, m_q, m_hit;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_low = 0; m_en = 0; m_pend = 0; m_prev = 0;
        end else begin
            m_q = ppu_a12 && !m_prev && (m_low >= 3);
            if (ppu_a12) m_low = 0;
            else if (cpu_tick && m_low < 3) m_low = m_low + 1;
            m_prev = ppu_a12;
            m_hit = cpu_we && (cpu_addr[15:12] == 4'hC);
            if (m_hit) begin
                case (cpu_addr[2:0])
                    3'd2: begin m_en = 0; m_pend = 0; end
                    3'd3: m_en = 1;
                    3'd5: m_cnt = cpu_data;
                    default: ;
                endcase
            end else if (m_q && m_en) begin
                if (m_cnt != 0) m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin m_pend = 1; m_en = 0; end
            end
        end
    end

    // Per-cycle comparison (R10: irq equals pending).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                total++;
                if (irq !== m_pend) begin
                    fails++;
                    $display("FAIL R10 model compare during %s: actual=%0b expected=%0b",
                             cur_req, irq, m_pend);
                end
            end
        end
    end

    task automatic chk(input logic exp, input string req);
        total++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s: irq actual=%0b expected=%0b", req, irq, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic pulse(input int low_clks);
        @(negedge clk);
        ppu_a12 = 1'b0;
        repeat (low_clks) @(negedge clk);
        ppu_a12 = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_with_write(input logic [15:0] a);
        @(negedge clk);
        ppu_a12 = 1'b0;
        repeat (12) @(negedge clk);
        ppu_a12 = 1'b1;
        cpu_addr = a; cpu_data = 8'h00; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b0, "R1 reset irq");

        // R5, R7: load 3, arm, fire on third counted rise.
        cur_req = "R7";
        wr(16'hC005, 8'd3);
        wr(16'hC003, 8'd0);
        pulse(12); chk(1'b0, "R7 after 1 rise");
        pulse(12); chk(1'b0, "R7 after 2 rises");
        pulse(12); chk(1'b1, "R7/R5 fires on 3rd rise");

        // R10: stays high, disarmed.
        cur_req = "R10";
        pulse(12); pulse(12); chk(1'b1, "R10 pending held");

        // R4: arm keeps pending.
        cur_req = "R4";
        wr(16'hC003, 8'd0); chk(1'b1, "R4 arm keeps pending");

        // R3: ack clears.
        cur_req = "R3";
        wr(16'hC002, 8'd0); chk(1'b0, "R3 ack clears irq");

        // R8: counter at zero fires on next rise.
        cur_req = "R8";
        wr(16'hC003, 8'd0);
        pulse(12); chk(1'b1, "R8 zero count fires at once");
        wr(16'hC002, 8'd0);

        // R2: bits 11:3 ignored.
        cur_req = "R2";
        wr(16'hC80D, 8'd2);
        wr(16'hCFFB, 8'd0);
        pulse(12); chk(1'b0, "R2 aliased load/arm, 1 rise");
        pulse(12); chk(1'b1, "R2 aliased load/arm, 2 rises");
        wr(16'hCF7A, 8'd0); chk(1'b0, "R2 aliased ack");

        // R2: other page ignored.
        wr(16'hC005, 8'd2);
        wr(16'hD005, 8'd1);
        wr(16'hC003, 8'd0);
        pulse(12); chk(1'b0, "R2 other page load ignored");
        pulse(12); chk(1'b1, "R2 count from own page");
        wr(16'hC002, 8'd0);

        // R6: short low phase ignored.
        cur_req = "R6";
        wr(16'hC005, 8'd1);
        wr(16'hC003, 8'd0);
        pulse(3); chk(1'b0, "R6 short low not counted");
        pulse(12); chk(1'b1, "R6 long low counted");
        wr(16'hC002, 8'd0);

        // R9: disarmed rises ignored, count held.
        cur_req = "R9";
        wr(16'hC005, 8'd2);
        for (int i = 0; i < 5; i++) pulse(12);
        chk(1'b0, "R9 disarmed no irq");
        wr(16'hC003, 8'd0);
        pulse(12); chk(1'b0, "R9 count held at 2, first rise");
        pulse(12); chk(1'b1, "R9 count held at 2, second rise");
        wr(16'hC002, 8'd0);

        // R11: write in the rise cycle discards the rise.
        cur_req = "R11";
        wr(16'hC005, 8'd1);
        wr(16'hC003, 8'd0);
        pulse_with_write(16'hC000);
        chk(1'b0, "R11 rise dropped on write");
        pulse(12); chk(1'b1, "R11 next rise counts");
        wr(16'hC002, 8'd0);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++; fails++;
        $display("FAIL R10 watchdog: actual=timeout expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule